// File: doc/BRIEF.md
# Append-Only Wiper Slot Store Controller

This block sits between a command executor and a small one-time-programmable store. The store is modelled as a register array with a 6-bit address. It holds up to a parameterised number of wiper values, 50 by default, in slots 1 and upward. It also holds two factory tolerance words at fixed addresses near the top of the address space. A store request always appends: it writes the next free slot. Slots are never rewritten. Each program occupies the block for a long, parameterised number of clock cycles. A success flag reports how the most recent program ended, and a counter reports the highest slot written so far.

A restore request returns the newest stored wiper value, or midscale if nothing has been stored yet. A restore also runs by itself after every reset, using a longer power-up delay. Slot reads and reads of the last-slot counter answer in the following cycle. While any program or restore is running, the block holds `busy` high. The serial front end uses `busy` to stop acknowledging its address. Any request that arrives while `busy` is high is refused with a one-cycle error pulse and changes nothing.

Top module: `otp_slot_ctrl`

## Requirements
- R1: While reset is held and for exactly PWRUP_CYC cycles after it is released, `busy` is 1, `success` is 0 and `last_slot` is 0. In the cycle after that, `restore_valid` pulses with the midscale value 2^(DATA_W-1) (512 for 10 bits).
- R2: A store (opcode 0) writes `req_wiper` into slot `last_slot`+1. The first store goes to slot 1. When the program completes, `last_slot` rises by exactly one.
- R3: From the cycle after a store is accepted on a store that is not full, `busy` is 1 for exactly PROG_CYC cycles.
- R4: An accepted store clears `success` in the next cycle. `success` becomes 1 in the same cycle that `busy` falls at the end of the program.
- R5: Once SLOT_CNT slots hold data, a store writes nothing and does not raise `busy`. `success` is 0 in the next cycle and `last_slot` stays at SLOT_CNT.
- R6: A restore (opcode 1) holds `busy` for exactly RST_CYC cycles. In the cycle after that, `restore_valid` pulses with the newest slot's value, or with midscale if no slot is written.
- R7: A slot read (opcode 2) returns, one cycle later on `rsp_valid`/`rsp_data`, the word at the 6-bit `req_addr`. Address 0, unwritten slots and unassigned addresses read as zero.
- R8: Address 0x39 reads the parameter TOL_HI and address 0x3A reads TOL_LO, both zero-extended. TOL_HI carries the sign in bit 7 (1 = positive) and the integer percent in bits 6:0. TOL_LO carries the fraction in units of 2^-8.
- R9: A last-slot read (opcode 3) returns, one cycle later, the number of the last programmed slot in the low six bits of `rsp_data`, or 0 if none.
- R10: A request while `busy` is 1 gives `err`=1 in the next cycle and no response, and it changes neither slot contents nor `last_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; release starts the power-up restore |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | 0 store, 1 restore, 2 read slot, 3 read last slot |
| req_addr | input | ADDR_W | Location for a slot read |
| req_wiper | input | DATA_W | Wiper value to store |
| busy | output | 1 | Program or restore running; requests are refused |
| err | output | 1 | One-cycle pulse: a request arrived while busy |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | DATA_W | Read response data |
| restore_valid | output | 1 | Restore result strobe |
| restore_data | output | DATA_W | Restored wiper value |
| success | output | 1 | Last program completed |
| last_slot | output | ADDR_W | Highest programmed slot |

## Verification
The bench keeps the default depth of 50 slots, so the full address range up to 0x32 and the saturation case are both exercised. It shortens PROG_CYC to 20, RST_CYC to 4 and PWRUP_CYC to 12 cycles. With these values, filling every slot and then storing once more takes about a thousand cycles. The cycle-exact width of each busy window can then be counted directly. The bench supplies its own negative tolerance words (0x0C, 0xA0) so that the sign and fraction fields are seen as distinct, nonzero values.

// File: rtl/otp_slot_pkg.sv
package otp_slot_pkg;

   typedef enum logic [1:0] {
      OPC_STORE     = 2'd0,
      OPC_RESTORE   = 2'd1,
      OPC_READ_SLOT = 2'd2,
      OPC_READ_LAST = 2'd3
   } otp_op_e;

   typedef enum logic [1:0] {
      PEND_NONE    = 2'd0,
      PEND_PROG    = 2'd1,
      PEND_RESTORE = 2'd2
   } otp_pend_e;

endpackage

// File: rtl/otp_busy_timer.sv
module otp_busy_timer #(
   parameter int CNT_W     = 8,
   parameter int RESET_CNT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             last
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= CNT_W'(RESET_CNT);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
   assign last = (cnt == CNT_W'(1));

   // R10
   load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);

endmodule

// File: rtl/otp_slot_array.sv
module otp_slot_array #(
   parameter int          DATA_W      = 10,
   parameter int          ADDR_W      = 6,
   parameter int          SLOT_CNT    = 50,
   parameter int          TOL_HI_ADDR = 57,
   parameter int          TOL_LO_ADDR = 58,
   parameter logic [7:0]  TOL_HI      = 8'h00,
   parameter logic [7:0]  TOL_LO      = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [DATA_W-1:0] rd_data_b
);

   localparam int DEPTH = 2 ** ADDR_W;

   logic [DEPTH-1:0][DATA_W-1:0] mem;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      if (g >= 1 && g <= SLOT_CNT) begin : g_slot
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
               q <= wr_data;
         end
         assign mem[g] = q;
      end else if (g == TOL_HI_ADDR) begin : g_tol_hi
         assign mem[g] = DATA_W'(TOL_HI);
      end else if (g == TOL_LO_ADDR) begin : g_tol_lo
         assign mem[g] = DATA_W'(TOL_LO);
      end else begin : g_blank
         assign mem[g] = '0;
      end
   end

   assign rd_data_a = mem[rd_addr_a];
   assign rd_data_b = mem[rd_addr_b];

   // R2
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr >= ADDR_W'(1) && wr_addr <= ADDR_W'(SLOT_CNT)));

endmodule

// File: rtl/otp_slot_ctrl.sv
module otp_slot_ctrl
   import otp_slot_pkg::*;
#(
   parameter int         DATA_W    = 10,
   parameter int         ADDR_W    = 6,
   parameter int         SLOT_CNT  = 50,
   parameter int         PROG_CYC  = 1000,
   parameter int         RST_CYC   = 200,
   parameter int         PWRUP_CYC = 5000,
   parameter logic [7:0] TOL_HI    = 8'h80,
   parameter logic [7:0] TOL_LO    = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wiper,
   output logic              busy,
   output logic              err,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              restore_valid,
   output logic [DATA_W-1:0] restore_data,
   output logic              success,
   output logic [ADDR_W-1:0] last_slot
);

   localparam int DEPTH       = 2 ** ADDR_W;
   localparam int TOL_HI_ADDR = DEPTH - 7;
   localparam int TOL_LO_ADDR = DEPTH - 6;
   localparam int MAX_A       = (PROG_CYC > RST_CYC) ? PROG_CYC : RST_CYC;
   localparam int MAX_CYC     = (MAX_A > PWRUP_CYC) ? MAX_A : PWRUP_CYC;
   localparam int CNT_W       = $clog2(MAX_CYC + 1);
   localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);

   if (SLOT_CNT < 1 || SLOT_CNT >= TOL_HI_ADDR) begin : g_bad_slots
      $error("SLOT_CNT must fit below the tolerance words");
   end
   if (DATA_W < 8 || DATA_W < ADDR_W) begin : g_bad_width
      $error("DATA_W must hold a tolerance byte and a slot number");
   end
   if (PROG_CYC < 1 || RST_CYC < 1 || PWRUP_CYC < 1) begin : g_bad_timing
      $error("timing parameters must be at least one cycle");
   end

   otp_op_e           op;
   otp_pend_e         pend;
   logic [ADDR_W-1:0] slot_cnt;
   logic [DATA_W-1:0] hold_data;
   logic [DATA_W-1:0] rd_a, rd_b;
   logic              accept, full, tmr_load, tmr_last;
   logic [CNT_W-1:0]  tmr_val;

   assign op       = otp_op_e'(req_op);
   assign accept   = req_valid && !busy;
   assign full     = (slot_cnt == ADDR_W'(SLOT_CNT));
   assign tmr_load = accept && ((op == OPC_STORE && !full) || op == OPC_RESTORE);
   assign tmr_val  = (op == OPC_STORE) ? CNT_W'(PROG_CYC) : CNT_W'(RST_CYC);

   otp_busy_timer #(
      .CNT_W     (CNT_W),
      .RESET_CNT (PWRUP_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .busy     (busy),
      .last     (tmr_last)
   );

   otp_slot_array #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .SLOT_CNT    (SLOT_CNT),
      .TOL_HI_ADDR (TOL_HI_ADDR),
      .TOL_LO_ADDR (TOL_LO_ADDR),
      .TOL_HI      (TOL_HI),
      .TOL_LO      (TOL_LO)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (tmr_last && pend == PEND_PROG),
      .wr_addr   (slot_cnt + 1'b1),
      .wr_data   (hold_data),
      .rd_addr_a (req_addr),
      .rd_data_a (rd_a),
      .rd_addr_b (slot_cnt),
      .rd_data_b (rd_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_cnt      <= '0;
         success       <= 1'b0;
         pend          <= PEND_RESTORE;
         hold_data     <= '0;
         err           <= 1'b0;
         rsp_valid     <= 1'b0;
         rsp_data      <= '0;
         restore_valid <= 1'b0;
         restore_data  <= '0;
      end else begin
         err           <= req_valid && busy;
         rsp_valid     <= 1'b0;
         restore_valid <= 1'b0;
         if (accept) begin
            case (op)
               OPC_STORE: begin
                  success <= 1'b0;
                  if (!full) begin
                     pend      <= PEND_PROG;
                     hold_data <= req_wiper;
                  end
               end
               OPC_RESTORE: pend <= PEND_RESTORE;
               OPC_READ_SLOT: begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= rd_a;
               end
               default: begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= DATA_W'(slot_cnt);
               end
            endcase
         end
         if (tmr_last) begin
            case (pend)
               PEND_PROG: begin
                  slot_cnt <= slot_cnt + 1'b1;
                  success  <= 1'b1;
               end
               PEND_RESTORE: begin
                  restore_valid <= 1'b1;
                  restore_data  <= (slot_cnt == '0) ? MIDSCALE : rd_b;
               end
               default: ;
            endcase
            pend <= PEND_NONE;
         end
      end
   end

   assign last_slot = slot_cnt;

   // R3
   store_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && op == OPC_STORE && !full) |=> busy);

   // R10
   reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && busy) |=> (err && !rsp_valid));

   // R5
   slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_cnt <= ADDR_W'(SLOT_CNT));

   // R2
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(slot_cnt) |-> slot_cnt == ADDR_W'($past(slot_cnt) + 1'b1));

   // R4
   success_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(success) |-> $fell(busy));

   // R6
   restore_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restore_valid |-> !busy);

endmodule

// File: tb/otp_slot_ctrl_bench.sv
module otp_slot_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DW    = 10;
   localparam int AW    = 6;
   localparam int SLOTS = 50;
   localparam int PROG  = 20;
   localparam int RST   = 4;
   localparam int PWRUP = 12;
   localparam logic [7:0] T_HI = 8'h0C;
   localparam logic [7:0] T_LO = 8'hA0;
   localparam logic [DW-1:0] MID = 10'd512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wiper = '0;
   logic          busy, err, rsp_valid, restore_valid, success;
   logic [DW-1:0] rsp_data, restore_data;
   logic [AW-1:0] last_slot;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] mdl [0:63];
   int            mdl_cnt = 0;

   logic [DW-1:0] rsp_q[$];
   string         rsp_tag[$];
   logic [DW-1:0] rst_q[$];
   string         rst_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   otp_slot_ctrl #(
      .DATA_W(DW), .ADDR_W(AW), .SLOT_CNT(SLOTS), .PROG_CYC(PROG),
      .RST_CYC(RST), .PWRUP_CYC(PWRUP), .TOL_HI(T_HI), .TOL_LO(T_LO)
   ) u_otp_slot_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wiper(req_wiper), .busy(busy), .err(err),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .restore_valid(restore_valid), .restore_data(restore_data),
      .success(success), .last_slot(last_slot)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (rsp_q.size() == 0) chk("R10 unexpected response", 1, 0);
         else chk(rsp_tag.pop_front(), int'(rsp_data), int'(rsp_q.pop_front()));
      end
      if (rst_n && restore_valid) begin
         if (rst_q.size() == 0) chk("R6 unexpected restore", 1, 0);
         else chk(rst_tag.pop_front(), int'(restore_data), int'(rst_q.pop_front()));
      end
   end

   // one request, one accepting edge; returns at the following negedge
   task automatic issue(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] v);
      req_valid = 1'b1; req_op = op; req_addr = a; req_wiper = v;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic count_busy(string tag, int start, int exp);
      int n = start;
      while (busy) begin n++; @(negedge clk); end
      chk(tag, n, exp);
   endtask

   task automatic rd_slot(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
      rsp_q.push_back(exp); rsp_tag.push_back(tag);
      issue(2'd2, a, '0);
   endtask

   task automatic rd_last(string tag);
      rsp_q.push_back(DW'(mdl_cnt)); rsp_tag.push_back(tag);
      issue(2'd3, '0, '0);
   endtask

   task automatic do_restore();
      rst_q.push_back(mdl_cnt == 0 ? MID : mdl[mdl_cnt]);
      rst_tag.push_back("R6 restore value");
      issue(2'd1, '0, '0);
      count_busy("R6 restore busy length", 0, RST);
      @(negedge clk);
   endtask

   task automatic do_store(logic [DW-1:0] v, bit poke);
      int st = 0;
      issue(2'd0, '0, v);
      chk("R4 success cleared on accept", int'(success), 0);
      chk("R3 busy after accept", int'(busy), 1);
      if (poke) begin
         issue(2'd2, 6'd1, '0);
         chk("R10 err on read while busy", int'(err), 1);
         issue(2'd0, '0, 10'h155);
         chk("R10 err on store while busy", int'(err), 1);
         st = 2;
      end
      count_busy("R3 program busy length", st, PROG);
      mdl_cnt++;
      mdl[mdl_cnt] = v;
      chk("R4 success after program", int'(success), 1);
      chk("R2 last slot advanced", int'(last_slot), mdl_cnt);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk("watchdog expired", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mdl[i] = '0;
      rst_q.push_back(MID); rst_tag.push_back("R1 power-up midscale");
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", int'(busy), 1);
      chk("R1 success in reset", int'(success), 0);
      chk("R1 last slot in reset", int'(last_slot), 0);
      rst_n = 1'b1;
      count_busy("R1 power-up busy length", 0, PWRUP);
      @(negedge clk);

      rd_last("R9 nothing programmed");
      rd_slot(6'd1, '0, "R7 unwritten slot");
      rd_slot(6'h39, DW'(T_HI), "R8 tolerance sign/integer");
      rd_slot(6'h3A, DW'(T_LO), "R8 tolerance fraction");
      do_restore();

      do_store(10'h100, 1'b1);
      chk("R10 rejected store left count", int'(last_slot), 1);
      do_store(10'h2AB, 1'b0);
      do_store(10'h3FF, 1'b0);
      rd_slot(6'd1, 10'h100, "R7 slot 1");
      rd_slot(6'd2, 10'h2AB, "R7 slot 2");
      rd_slot(6'd3, 10'h3FF, "R7 slot 3");
      rd_slot(6'd4, '0, "R7 next free slot");
      rd_slot(6'd0, '0, "R7 reserved location");
      rd_last("R9 three programmed");
      do_restore();

      for (int i = 4; i <= SLOTS; i++) do_store(DW'(i * 19 + 3), 1'b0);
      rd_last("R9 full array");
      rd_slot(6'h32, mdl[SLOTS], "R7 last slot 0x32");

      issue(2'd0, '0, 10'h0AA);
      chk("R5 no busy when full", int'(busy), 0);
      chk("R5 success stays 0 when full", int'(success), 0);
      chk("R5 last slot saturated", int'(last_slot), SLOTS);
      rd_slot(6'h33, '0, "R5 nothing past 0x32");
      do_restore();
      rd_slot(6'h38, '0, "R7 unassigned location");

      repeat (3) @(negedge clk);
      chk("R7 responses pending", rsp_q.size(), 0);
      chk("R6 restores pending", rst_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule